// File: doc/BRIEF.md
# Half-Flash ADC Conversion Controller

This block is a synchronous host-side sequencer for an external 10-bit two-step (coarse then fine) converter. It drives the converter's active-low chip select, sample/hold and read strobes and its two channel-select lines. It watches the converter's active-low end-of-conversion interrupt and captures the 10-bit result from the data bus. A one-cycle start request with a channel number and a mode bit begins a conversion. The result comes back with a one-cycle valid pulse. If the interrupt never arrives, the block instead gives a one-cycle error pulse.

Two strobe modes are supported. In split mode (`mode_i` = 0), sample/hold is pulsed low for a fixed number of cycles. Its rising edge starts the fine phase, and read is pulsed only after the interrupt falls. In joint mode (`mode_i` = 1), sample/hold and read fall together and stay low until the result is captured. In this mode the bus shows the previous result until the interrupt falls, so that data must not be taken. Every pulse width and wait is a cycle-count parameter. The interrupt passes through a two-stage synchronizer before it is used.

Top module: `hfadc_ctrl`

## Requirements
- R1: After reset, chip select, sample/hold and read are high, and busy, valid and error are low.
- R2: The channel-select outputs carry `chan_i` as a binary code (00 = channel 0 through 11 = channel 3). They are set when the start is accepted, at least SETUP_CYC cycles before sample/hold falls, and they do not change while busy is high.
- R3: Chip select is low in every cycle in which sample/hold or read is low.
- R4: In split mode, sample/hold stays low for exactly SAMPLE_CYC cycles. Read stays high until the synchronized interrupt has been seen low.
- R5: In joint mode, sample/hold and read fall in the same cycle and rise in the same cycle.
- R6: The result is the bus value sampled SETTLE_CYC cycles after the synchronized interrupt is first seen low. The valid pulse comes exactly SETTLE_CYC + 4 cycles after the edge where the interrupt input falls. Bus data present before the interrupt falls is never reported.
- R7: In the cycle of the valid pulse, all three strobes are already high, which releases the interrupt.
- R8: If the interrupt is still high TIMEOUT_CYC cycles after the wait for it begins, the block gives a one-cycle error pulse with no valid pulse and releases all strobes.
- R9: A start request made while busy is high is ignored. It starts no second conversion and does not change the channel in use.
- R10: Busy rises in the cycle after an accepted start and falls in the cycle after the valid or error pulse. `chan_i` and `mode_i` are sampled only when the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 2 | Channel to convert |
| mode_i | input | 1 | 0 = split strobes, 1 = joint strobe |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 10 | Last captured conversion result |
| valid_o | output | 1 | One-cycle pulse when a new result is ready |
| err_o | output | 1 | One-cycle pulse when the conversion times out |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sh_n | output | 1 | Converter sample/hold strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_sel | output | 2 | Converter channel select |
| adc_int_n | input | 1 | Converter end-of-conversion, active low |
| adc_data | input | 10 | Converter data bus |

## Verification
The hardest case to reach is a joint-mode conversion that finishes very quickly. The bus still holds the previous conversion's code until the interrupt falls, and a controller that captures early would return a plausible but stale value. The bench's converter model keeps the previous code on the bus in joint mode and puts an inverted pattern on it in split mode. It sets the interrupt delay per conversion, from one cycle up to past the timeout. Each capture is compared with the new code and with the exact cycle distance from the interrupt edge. Start pulses injected mid-conversion and timeouts in both modes complete the set.

// File: rtl/hfadc_pkg.sv
// Shared types for the half-flash converter controller.
// Assumes: one conversion at a time, phases visited in declaration order.
package hfadc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_SAMPLE,
        PH_WAIT,
        PH_SETTLE
    } phase_t;
endpackage

// File: rtl/hfadc_sync.sv
// Multi-stage synchronizer for an asynchronous active-low level.
// Assumes: the idle level is high, so every stage resets to 1.
module hfadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // shift the input through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hfadc_timer.sv
// Loadable down-counter used for every phase of a conversion.
// Assumes: a load of N-1 makes expired true N cycles after the load edge.
module hfadc_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // load on request, otherwise count down to zero and hold there
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/hfadc_ctrl.sv
// Host-side sequencer for an external two-step 10-bit converter.
// Drives chip select, sample/hold, read and channel lines and captures the
// result after the synchronized end-of-conversion interrupt.
// Assumes: all *_CYC parameters are at least 1; adc_int_n is asynchronous.
module hfadc_ctrl #(
    parameter int DATA_W      = 10,
    parameter int CH_W        = 2,
    parameter int SETUP_CYC   = 2,
    parameter int SAMPLE_CYC  = 25,
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              mode_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              adc_cs_n,
    output logic              adc_sh_n,
    output logic              adc_rd_n,
    output logic [CH_W-1:0]   adc_sel,
    input  logic              adc_int_n,
    input  logic [DATA_W-1:0] adc_data
);
    import hfadc_pkg::*;

    localparam int MAX_A  = (SETUP_CYC > SAMPLE_CYC) ? SETUP_CYC : SAMPLE_CYC;
    localparam int MAX_B  = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW     = $clog2(MAX_C + 1);
    localparam logic [TW-1:0] LD_SETUP  = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] LD_SAMPLE = TW'(SAMPLE_CYC - 1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] LD_WAIT   = TW'(TIMEOUT_CYC - 1);

    phase_t        phase;
    logic          mode_q;
    logic          int_s;
    logic          tmr_exp;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          accept;

    hfadc_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_int_n),
        .dout  (int_s)
    );

    hfadc_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign busy_o = (phase != PH_IDLE) | valid_o | err_o;
    assign accept = start_i & ~busy_o;

    // choose when and with what the phase timer is reloaded
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = LD_SETUP;
        unique case (phase)
            PH_IDLE:   if (accept) begin tmr_load = 1'b1; tmr_val = LD_SETUP; end
            PH_SETUP:  if (tmr_exp) begin
                           tmr_load = 1'b1;
                           tmr_val  = mode_q ? LD_WAIT : LD_SAMPLE;
                       end
            PH_SAMPLE: if (tmr_exp) begin tmr_load = 1'b1; tmr_val = LD_WAIT; end
            PH_WAIT:   if (!int_s) begin tmr_load = 1'b1; tmr_val = LD_SETTLE; end
            default:   ;
        endcase
    end

    // conversion sequencer: strobes, channel lines, result and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            mode_q   <= 1'b0;
            adc_cs_n <= 1'b1;
            adc_sh_n <= 1'b1;
            adc_rd_n <= 1'b1;
            adc_sel  <= '0;
            result_o <= '0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            unique case (phase)
                PH_IDLE: if (accept) begin
                    adc_sel  <= chan_i;
                    mode_q   <= mode_i;
                    adc_cs_n <= 1'b0;
                    phase    <= PH_SETUP;
                end
                PH_SETUP: if (tmr_exp) begin
                    adc_sh_n <= 1'b0;
                    if (mode_q) begin
                        adc_rd_n <= 1'b0;
                        phase    <= PH_WAIT;
                    end else begin
                        phase    <= PH_SAMPLE;
                    end
                end
                PH_SAMPLE: if (tmr_exp) begin
                    adc_sh_n <= 1'b1;
                    phase    <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (!int_s) begin
                        adc_rd_n <= 1'b0;
                        phase    <= PH_SETTLE;
                    end else if (tmr_exp) begin
                        adc_cs_n <= 1'b1;
                        adc_sh_n <= 1'b1;
                        adc_rd_n <= 1'b1;
                        err_o    <= 1'b1;
                        phase    <= PH_IDLE;
                    end
                end
                PH_SETTLE: if (tmr_exp) begin
                    result_o <= adc_data;
                    valid_o  <= 1'b1;
                    adc_cs_n <= 1'b1;
                    adc_sh_n <= 1'b1;
                    adc_rd_n <= 1'b1;
                    phase    <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hfadc_ctrl_chk.sv
// Protocol checker for hfadc_ctrl, attached by bind.
// Assumes: mode_q and int_s are the controller's latched mode and
// synchronized interrupt.
module hfadc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       valid_o,
    input logic       err_o,
    input logic       adc_cs_n,
    input logic       adc_sh_n,
    input logic       adc_rd_n,
    input logic [1:0] adc_sel,
    input logic       mode_q,
    input logic       int_s
);
    // R3
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_sh_n || !adc_rd_n) |-> !adc_cs_n);
    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(adc_sel));
    // R4
    split_rd_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !adc_sh_n) |-> adc_rd_n);
    // R4
    split_rd_after_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && $fell(adc_rd_n)) |-> !$past(int_s));
    // R5
    joint_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !adc_cs_n) |-> (adc_sh_n == adc_rd_n));
    // R7
    release_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (adc_cs_n && adc_sh_n && adc_rd_n));
    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!valid_o && adc_cs_n && adc_sh_n && adc_rd_n));
    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(valid_o || err_o));
endmodule

bind hfadc_ctrl hfadc_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .err_o    (err_o),
    .adc_cs_n (adc_cs_n),
    .adc_sh_n (adc_sh_n),
    .adc_rd_n (adc_rd_n),
    .adc_sel  (adc_sel),
    .mode_q   (mode_q),
    .int_s    (int_s)
);

// File: tb/hfadc_ctrl_test.sv
module hfadc_ctrl_test;
    localparam int SAMPLE = 25;
    localparam int SETTLE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] chan_i = 2'd0;
    logic       mode_i = 1'b0;
    logic       busy_o, valid_o, err_o;
    logic [9:0] result_o;
    logic       adc_cs_n, adc_sh_n, adc_rd_n;
    logic [1:0] adc_sel;
    logic       adc_int_n = 1'b1;
    logic [9:0] adc_data = 10'd0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // converter model state
    logic       sh_p = 1'b1, rd_p = 1'b1;
    logic [1:0] sh_sel = 2'd0;
    int         sh_w = 0;
    bit         tied_seen = 1'b0;
    bit         act = 1'b0;
    int         cnt = 0;
    int         conv_dly = 10;
    logic [9:0] model_code = 10'd0;
    int         int_fall_cyc = 0;
    int         sel_bad = 0;
    int         cs_bad = 0;
    int         seq = 0;

    hfadc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .mode_i(mode_i), .busy_o(busy_o), .result_o(result_o),
        .valid_o(valid_o), .err_o(err_o), .adc_cs_n(adc_cs_n),
        .adc_sh_n(adc_sh_n), .adc_rd_n(adc_rd_n), .adc_sel(adc_sel),
        .adc_int_n(adc_int_n), .adc_data(adc_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural converter: interrupt after conv_dly, stale bus before it
    always @(posedge clk) begin
        sh_p <= adc_sh_n;
        rd_p <= adc_rd_n;
        if (!rst_n) begin
            adc_int_n <= 1'b1;
            act <= 1'b0;
        end else begin
            if (!adc_sh_n && sh_p) begin
                sh_sel    <= adc_sel;
                sh_w      <= 1;
                tied_seen <= !adc_rd_n;
                if (!adc_rd_n) begin act <= 1'b1; cnt <= conv_dly; end
                else adc_data <= ~model_code;
            end else if (!adc_sh_n) begin
                sh_w <= sh_w + 1;
            end
            if (adc_sh_n && !sh_p && adc_rd_n && !adc_cs_n) begin
                act <= 1'b1; cnt <= conv_dly;
            end
            if (act) begin
                if (cnt <= 1) begin
                    adc_int_n <= 1'b0; adc_data <= model_code;
                    act <= 1'b0; int_fall_cyc <= cyc;
                end else cnt <= cnt - 1;
            end
            if (adc_rd_n && !rd_p) adc_int_n <= 1'b1;
            if (adc_cs_n) act <= 1'b0;
        end
    end

    // protocol monitors for channel hold and chip-select gating
    always @(posedge clk) begin
        if (rst_n) begin
            if ((!adc_sh_n || !adc_rd_n) && adc_cs_n) cs_bad++;
            if (!adc_sh_n && !sh_p && adc_sel != sh_sel) sel_bad++;
        end
    end

    function automatic logic [9:0] code_of(input logic [1:0] ch, input int s);
        return {ch, 8'(s * 37 + 5)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic conv(input logic [1:0] ch, input bit md, input int dly,
                        input bit intrude, input bit want_to);
        int n;
        seq++;
        model_code = code_of(ch, seq);
        conv_dly = dly;
        @(negedge clk);
        start_i = 1'b1; chan_i = ch; mode_i = md;
        @(negedge clk);
        start_i = 1'b0; chan_i = ~ch; mode_i = ~md;
        chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
        if (intrude) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!valid_o && !err_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (want_to) begin
            chk(err_o == 1'b1, "R8 error pulse", int'(err_o), 1);
            chk(valid_o == 1'b0, "R8 no valid", int'(valid_o), 0);
            chk(adc_cs_n && adc_sh_n && adc_rd_n, "R8 strobes released",
                int'({adc_cs_n, adc_sh_n, adc_rd_n}), 7);
        end else begin
            chk(valid_o == 1'b1, "R6 valid pulse", int'(valid_o), 1);
            chk(result_o == model_code, "R6 result", int'(result_o), int'(model_code));
            chk(cyc - int_fall_cyc == SETTLE + 4, "R6 capture timing",
                cyc - int_fall_cyc, SETTLE + 4);
            chk(sh_sel == ch, "R2 channel code", int'(sh_sel), int'(ch));
            if (!md) chk(sh_w == SAMPLE, "R4 sample width", sh_w, SAMPLE);
            else     chk(tied_seen, "R5 joint fall", int'(tied_seen), 1);
            chk(adc_cs_n && adc_sh_n && adc_rd_n, "R7 strobes released",
                int'({adc_cs_n, adc_sh_n, adc_rd_n}), 7);
        end
        @(negedge clk);
        chk(busy_o == 1'b0, "R10 busy falls", int'(busy_o), 0);
        if (intrude) begin
            repeat (3) @(negedge clk);
            chk(adc_cs_n && !busy_o, "R9 no second conversion",
                int'({adc_cs_n, busy_o}), 2);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(adc_cs_n && adc_sh_n && adc_rd_n, "R1 strobes idle",
            int'({adc_cs_n, adc_sh_n, adc_rd_n}), 7);
        chk(!busy_o && !valid_o && !err_o, "R1 flags clear",
            int'({busy_o, valid_o, err_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corner cases
        conv(2'd0, 1'b0, 60, 1'b0, 1'b0);
        conv(2'd3, 1'b1, 85, 1'b0, 1'b0);
        conv(2'd1, 1'b1, 1, 1'b0, 1'b0);   // R6 fast joint, stale bus
        conv(2'd2, 1'b0, 1, 1'b0, 1'b0);
        conv(2'd1, 1'b0, 40, 1'b1, 1'b0);  // R9 split intrusion
        conv(2'd2, 1'b1, 40, 1'b1, 1'b0);  // R9 joint intrusion
        conv(2'd3, 1'b1, 100000, 1'b0, 1'b1); // R8 joint timeout
        conv(2'd0, 1'b0, 100000, 1'b0, 1'b1); // R8 split timeout
        conv(2'd1, 1'b1, 20, 1'b0, 1'b0);  // recovery after timeout
        // random mix
        for (int i = 0; i < 24; i++) begin
            conv(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(1, 90)), 1'($urandom_range(0, 1)), 1'b0);
        end
        chk(sel_bad == 0, "R2 channel held", sel_bad, 0);
        chk(cs_bad == 0, "R3 chip select gating", cs_bad, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule